// File: doc/BRIEF.md
# Watermark/Timeout Burst Release Buffer

The block sits in an outgoing packet path. Packets arrive as a valid/ready word stream, where a marker flags the final word of each packet. The block holds these words and does not forward them as they arrive. It releases the stored packets as one burst when either of two conditions occurs. The first is that the number of stored words reaches a watermark. The second is that a programmable idle timer expires while a complete packet is waiting. A burst always ends on a packet boundary. A packet that is still arriving stays in the buffer until a later burst.

A single write strobe loads the configuration: a 3-bit level code and a timeout count. The level code picks one of three watermark thresholds, and any code above 2 is stored as 2. The stored level and timeout can be read back on output ports. The inbound-request direction and the outbound-request direction each use a separate instance with its own settings.

Top module: `flush_buffer`

## Requirements
- R1: After reset, out_valid_o is 0, in_ready_o is 1, cfg_level_o reads 1, and cfg_tmo_o reads the TMO_RST parameter.
- R2: Stored level 0, 1 and 2 select watermarks of THR0, THR1 and THR2 words (default 4, 8, 16). A burst is not released while the stored word count is below the watermark and the timer has not expired. When the count reaches the watermark and at least one complete packet is held, out_valid_o rises one clock cycle after the edge that stored the word reaching the watermark.
- R3: A write with cfg_level_i above 2 stores level 2. The value reads back as 2 on cfg_level_o and selects the THR2 watermark.
- R4: The idle timer restarts from zero when a word enters an empty buffer, and it is held at zero during a burst. Suppose a complete packet is held below the watermark. Then out_valid_o rises T+1 cycles after the edge that stored the first word, where T is the stored timeout.
- R5: A burst releases only whole packets, and out_last_o marks the final word of each one. Words of a packet without its final word stay held, and out_valid_o drops after the last complete packet.
- R6: Words leave in arrival order with data and last marker unchanged. While out_valid_o is high and out_ready_i is low, the output word stays stable.
- R7: A burst started by either trigger drains every complete packet held when it started as one continuous release. in_ready_o is 0 while the burst runs.
- R8: When the buffer holds DEPTH words, in_ready_o is 0 and no word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for level and timeout |
| cfg_level_i | input | 3 | Level code to store (clamped to 2) |
| cfg_tmo_i | input | TW | Timeout in cycles |
| cfg_level_o | output | 2 | Stored level |
| cfg_tmo_o | output | TW | Stored timeout |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted when high |
| in_data_i | input | W | Input word |
| in_last_i | input | 1 | Input word ends a packet |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts the word |
| out_data_o | output | W | Output word |
| out_last_o | output | 1 | Output word ends a packet |

## Verification
The watermark crossing and the timer expiry can both fall in the same cycle. To provoke this, the timeout is set to 3 and four one-word packets are sent back to back at level 0, so both conditions become true after the fourth word is stored. The test passes only if exactly one burst starts, four cycles after the first word and one cycle after the fourth. That burst must carry all four words in order, and no second burst may follow.

// File: rtl/flush_buf_pkg.sv
package flush_buf_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_MAX = 2'd2;

  function automatic lvl_t clamp_lvl(input logic [2:0] code);
    return (code > 3'd2) ? LVL_MAX : lvl_t'(code[1:0]);
  endfunction
endpackage

// File: rtl/flush_buf_cfg.sv
module flush_buf_cfg
  import flush_buf_pkg::*;
#(
  parameter int TW      = 16,
  parameter int TMO_RST = 64,
  parameter int LVL_RST = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    level_i,
  input  logic [TW-1:0] tmo_i,
  output lvl_t          level_o,
  output logic [TW-1:0] tmo_o
);
  lvl_t          level_q;
  logic [TW-1:0] tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= lvl_t'(LVL_RST);
      tmo_q   <= TW'(TMO_RST);
    end else if (we_i) begin
      level_q <= clamp_lvl(level_i);
      tmo_q   <= tmo_i;
    end
  end

  assign level_o = level_q;
  assign tmo_o   = tmo_q;

  assert_level_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LVL_MAX);
endmodule

// File: rtl/flush_buf_fifo.sv
module flush_buf_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  input  logic          push_last_i,
  input  logic          pop_i,
  output logic [W-1:0]  pop_data_o,
  output logic          pop_last_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] pkts_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W:0]    mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q, pkts_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wptr_q] <= {push_last_i, push_data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      pkts_q  <= '0;
    end else begin
      if (push_i) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (pop_i)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      count_q <= count_q + CW'(push_i) - CW'(pop_i);
      pkts_q  <= pkts_q + CW'(push_i && push_last_i) - CW'(pop_i && pop_last_o);
    end
  end

  assign pop_data_o = mem[rptr_q][W-1:0];
  assign pop_last_o = mem[rptr_q][W];
  assign count_o    = count_q;
  assign pkts_o     = pkts_q;

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> count_q < CW'(DEPTH));
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count_q != '0);
endmodule

// File: rtl/flush_buf_ctrl.sv
module flush_buf_ctrl
  import flush_buf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int TW    = 16,
  parameter int THR0  = 4,
  parameter int THR1  = 8,
  parameter int THR2  = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  lvl_t          level_i,
  input  logic [TW-1:0] tmo_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] pkts_i,
  input  logic          out_fire_i,
  input  logic          out_last_i,
  output logic          drain_o
);
  logic [CW-1:0] thr, left_q;
  logic [TW-1:0] tmr_q;
  logic          drain_q, wm_hit, tmo_hit, start;

  always_comb begin
    unique case (level_i)
      2'd0:    thr = CW'(THR0);
      2'd1:    thr = CW'(THR1);
      default: thr = CW'(THR2);
    endcase
  end

  assign wm_hit  = count_i >= thr;
  assign tmo_hit = tmr_q >= tmo_i;
  assign start   = !drain_q && (pkts_i != '0) && (wm_hit || tmo_hit);

  // timer runs only while words wait outside a burst
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        tmr_q <= '0;
    else if (drain_q || count_i == '0)  tmr_q <= '0;
    else if (!tmo_hit)                  tmr_q <= tmr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_q <= 1'b0;
      left_q  <= '0;
    end else if (start) begin
      drain_q <= 1'b1;
      left_q  <= pkts_i;
    end else if (drain_q && out_fire_i && out_last_i) begin
      if (left_q == CW'(1)) drain_q <= 1'b0;
      left_q <= left_q - 1'b1;
    end
  end

  assign drain_o = drain_q;

  assert_burst_ends_on_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drain_q) |-> $past(out_fire_i && out_last_i));
  assert_burst_has_packet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drain_q) |-> left_q != '0);
endmodule

// File: rtl/flush_buffer.sv
module flush_buffer
  import flush_buf_pkg::*;
#(
  parameter int W       = 32,
  parameter int DEPTH   = 16,
  parameter int TW      = 16,
  parameter int TMO_RST = 64,
  parameter int THR0    = 4,
  parameter int THR1    = 8,
  parameter int THR2    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_level_i,
  input  logic [TW-1:0] cfg_tmo_i,
  output logic [1:0]    cfg_level_o,
  output logic [TW-1:0] cfg_tmo_o,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [W-1:0]  in_data_i,
  input  logic          in_last_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [W-1:0]  out_data_o,
  output logic          out_last_o
);
  localparam int CW = $clog2(DEPTH + 1);

  lvl_t          level;
  logic [CW-1:0] count, pkts;
  logic          drain, push, pop, full;

  assign cfg_level_o = level;

  flush_buf_cfg #(.TW(TW), .TMO_RST(TMO_RST), .LVL_RST(1)) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .level_i(cfg_level_i), .tmo_i(cfg_tmo_i),
    .level_o(level), .tmo_o(cfg_tmo_o)
  );

  assign full        = count == CW'(DEPTH);
  assign in_ready_o  = !full && !drain;
  assign push        = in_valid_i && in_ready_o;
  assign out_valid_o = drain && (count != '0);
  assign pop         = out_valid_o && out_ready_i;

  flush_buf_fifo #(.W(W), .DEPTH(DEPTH), .CW(CW)) i_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .push_data_i(in_data_i), .push_last_i(in_last_i),
    .pop_i(pop), .pop_data_o(out_data_o), .pop_last_o(out_last_o),
    .count_o(count), .pkts_o(pkts)
  );

  flush_buf_ctrl #(.DEPTH(DEPTH), .CW(CW), .TW(TW),
                   .THR0(THR0), .THR1(THR1), .THR2(THR2)) i_ctrl (
    .clk_i, .rst_ni,
    .level_i(level), .tmo_i(cfg_tmo_o),
    .count_i(count), .pkts_i(pkts),
    .out_fire_i(pop), .out_last_i(out_last_o),
    .drain_o(drain)
  );

  assert_out_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));
endmodule

// File: tb/test_flush_buffer.sv
module test_flush_buffer;
  localparam int W = 32;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [2:0] cfg_level_i = '0;
  logic [TW-1:0] cfg_tmo_i = '0;
  logic [1:0] cfg_level_o;
  logic [TW-1:0] cfg_tmo_o;
  logic in_valid_i = 1'b0, in_last_i = 1'b0;
  logic [W-1:0] in_data_i = '0;
  logic in_ready_o, out_valid_o, out_last_o, out_ready_i;
  logic [W-1:0] out_data_o;
  logic bp_mode = 1'b0;

  int cyc = 0, checks = 0, errors = 0;
  int n_out = 0, n_rise = 0, rise_cyc = 0, acc_cyc = 0;
  int seq = 100;
  bit prev_v = 1'b0, done = 1'b0;
  logic [W:0] exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign out_ready_i = !bp_mode || (cyc % 3 != 2);

  flush_buffer i_flush_buffer (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_level_i, .cfg_tmo_i, .cfg_level_o, .cfg_tmo_o,
    .in_valid_i, .in_ready_o, .in_data_i, .in_last_i,
    .out_valid_o, .out_ready_i, .out_data_o, .out_last_o
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard pop and burst-start observation
  always @(negedge clk) begin
    if (rst_ni) begin
      if (out_valid_o && !prev_v) begin
        rise_cyc = cyc;
        n_rise++;
        chk(in_ready_o == 1'b0, "R7", "in_ready during burst", int'(in_ready_o), 0);
      end
      prev_v = out_valid_o;
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) chk(1'b0, "R6", "unexpected output word", int'(out_data_o), -1);
        else begin
          logic [W:0] e;
          e = exp_q.pop_front();
          chk(out_data_o == e[W-1:0], "R6", "data order", int'(out_data_o), int'(e[W-1:0]));
          chk(out_last_o == e[W], "R5", "last marker", int'(out_last_o), int'(e[W]));
        end
        n_out++;
      end
    end
  end

  task automatic cfg(input logic [2:0] lvl, input int tmo);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_level_i = lvl; cfg_tmo_i = TW'(tmo);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic push_word(input bit last);
    in_valid_i = 1'b1; in_data_i = W'(seq); in_last_i = last;
    while (!in_ready_o) @(negedge clk);
    exp_q.push_back({last, W'(seq)});
    seq++;
    @(negedge clk);
    in_valid_i = 1'b0;
    acc_cyc = cyc;
  endtask

  task automatic push_pkt(input int len);
    for (int i = 0; i < len; i++) push_word(i == len - 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (exp_q.size() == 0 && !out_valid_o) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0, o0, first;
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(out_valid_o == 1'b0, "R1", "out_valid after reset", int'(out_valid_o), 0);
    chk(in_ready_o == 1'b1, "R1", "in_ready after reset", int'(in_ready_o), 1);
    chk(cfg_level_o == 2'd1, "R1", "default level", int'(cfg_level_o), 1);
    chk(cfg_tmo_o == TW'(64), "R1", "default timeout", int'(cfg_tmo_o), 64);

    // R2 level 0 watermark
    cfg(3'd0, 1000);
    r0 = n_rise; o0 = n_out;
    push_pkt(3);
    idle(30);
    chk(n_out == o0, "R2", "held below watermark 4", n_out - o0, 0);
    push_pkt(1);
    wait_idle();
    chk(rise_cyc - acc_cyc == 1, "R2", "release delay at watermark 4", rise_cyc - acc_cyc, 1);
    chk(n_rise - r0 == 1, "R7", "one burst for two packets", n_rise - r0, 1);
    chk(n_out - o0 == 4, "R7", "words drained", n_out - o0, 4);

    // R2 level 1 watermark
    cfg(3'd1, 1000);
    chk(cfg_level_o == 2'd1, "R2", "level 1 readback", int'(cfg_level_o), 1);
    o0 = n_out;
    push_pkt(7);
    idle(30);
    chk(n_out == o0, "R2", "held below watermark 8", n_out - o0, 0);
    push_pkt(1);
    wait_idle();
    chk(rise_cyc - acc_cyc == 1, "R2", "release delay at watermark 8", rise_cyc - acc_cyc, 1);

    // R3 clamp, R8 full
    cfg(3'd3, 1000);
    chk(cfg_level_o == 2'd2, "R3", "code 3 clamped", int'(cfg_level_o), 2);
    cfg(3'd5, 1000);
    chk(cfg_level_o == 2'd2, "R3", "code 5 clamped", int'(cfg_level_o), 2);
    o0 = n_out;
    push_pkt(5);
    push_pkt(10);
    idle(30);
    chk(n_out == o0, "R3", "held below watermark 16", n_out - o0, 0);
    push_pkt(1);
    chk(in_ready_o == 1'b0, "R8", "in_ready when full", int'(in_ready_o), 0);
    wait_idle();
    chk(rise_cyc - acc_cyc == 1, "R3", "release delay at watermark 16", rise_cyc - acc_cyc, 1);
    chk(n_out - o0 == 16, "R8", "words after full", n_out - o0, 16);

    // R4 timeout
    cfg(3'd2, 20);
    push_pkt(1);
    first = acc_cyc;
    wait_idle();
    chk(rise_cyc - first == 21, "R4", "timeout release delay", rise_cyc - first, 21);

    // R5 partial packet stays held
    cfg(3'd0, 1000);
    o0 = n_out;
    push_pkt(3);
    push_word(1'b0);
    push_word(1'b0);
    idle(40);
    chk(n_out - o0 == 3, "R5", "only whole packet released", n_out - o0, 3);
    chk(out_valid_o == 1'b0, "R5", "out_valid after whole packets", int'(out_valid_o), 0);
    chk(exp_q.size() == 2, "R5", "partial words held", exp_q.size(), 2);
    cfg(3'd0, 10);
    push_word(1'b1);
    wait_idle();
    chk(rise_cyc - acc_cyc == 1, "R5", "held packet released once complete", rise_cyc - acc_cyc, 1);

    // R2/R4 watermark and timer in the same cycle
    cfg(3'd0, 3);
    r0 = n_rise; o0 = n_out;
    push_pkt(1);
    first = acc_cyc;
    push_pkt(1);
    push_pkt(1);
    push_pkt(1);
    wait_idle();
    idle(20);
    chk(rise_cyc - first == 4, "R4", "coincident trigger delay", rise_cyc - first, 4);
    chk(n_rise - r0 == 1, "R7", "single burst on coincident triggers", n_rise - r0, 1);
    chk(n_out - o0 == 4, "R7", "coincident burst words", n_out - o0, 4);

    // R6 ordering under backpressure
    bp_mode = 1'b1;
    cfg(3'd1, 15);
    o0 = n_out;
    push_pkt(3);
    push_pkt(2);
    push_pkt(4);
    push_pkt(1);
    wait_idle();
    chk(n_out - o0 == 10, "R6", "words under backpressure", n_out - o0, 10);
    chk(exp_q.size() == 0, "R6", "scoreboard empty", exp_q.size(), 0);
    bp_mode = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule